// File: doc/BRIEF.md
# DRAM Command Subsequence Sequencer

This block drives raw DRAM commands onto one memory channel while no regular controller is in charge, as needed by memory training firmware. Software fills up to four slots through a simple write port. Each slot holds:

- one command;
- how many times that command is issued;
- the spacing between issues;
- a wait after the final issue;
- a read/write/none direction tag;
- a base column address, bank and rank;
- rules that step the bank or the column between issues.

A start word then launches the slot list, which may be repeated a number of times. The status output shows busy, and a pair of completion bits tells the polling software that the run has ended.

During a run the engine walks the slots from slot 0 up to the last valid one. For every issue it presents the command code, the stepped address and bank, an active-low chip select for the addressed rank, and a read or write strobe taken from the slot's direction tag. In timer mode the engine keeps exactly the same timing but drives no command, so a run can serve as a programmable delay.

Top module: `ds_cmd_sequencer`

## Requirements
- R1: After reset the status output is 0, cmd_valid is 0, every cmd_cs_n bit is 1 and both strobes are 0.
- R2: A write to cfg_addr 16 is a start word: bits [7:0] give the loop count (0 runs once), bits [19:18] give the number of valid slots minus one, and bit 22 selects timer mode. The first issue of slot 0 appears in the cycle after the start write is accepted.
- R3: Slot registers sit at cfg_addr = slot*4 + r. r=0 holds the command in bits [2:0] (NOP=0, ACT=1, RD=2, WR=3, PRE=4, MRS=5, ZQCS=6, alternate NOP=7). r=1 holds repeats [9:0] (0 counts as 1), gap [17:10], post wait [26:18] and direction [28:27] (0 none, 1 read, 2 write). r=2 holds column address [15:0], bank [18:16] and rank [20:19]. r=3 holds bank-step enable [0], column-step enable [1] and wrap [6:2].
- R4: A slot issues its command exactly "repeats" times, and successive issues are max(gap,1) cycles apart.
- R5: After a slot's last issue the engine waits the post count of idle cycles, so the next slot's first issue comes post+1 cycles after that last issue. Slots run in ascending index order from 0 to the last valid slot.
- R6: Stepping works on the 19-bit vector {bank, column}. A column step adds 8 and a bank step adds 1<<16 after each issue. Only the low "wrap" bits of the vector change: wrap 0 disables stepping, and a wrap of 19 or more lets every bit count. Each slot starts again from its own base.
- R7: During an issue exactly the cmd_cs_n bit selected by the slot's rank is 0. Outside an issue all cmd_cs_n bits are 1.
- R8: rd_strobe is 1 only during issues of a read-tagged slot, and wr_strobe is 1 only during issues of a write-tagged slot.
- R9: A loop count of N runs the whole slot list N times back to back, and every pass starts again from each slot's base address.
- R10: status bit 0 shows busy. Status bits 4 and 6 (mask 0x50) become 1 post+1 cycles after the final issue of the final pass. A newly accepted start clears them in the next cycle.
- R11: A start word written while the engine is busy is ignored and does not change the run in progress.
- R12: In timer mode the run keeps the normal timing and completion point, but cmd_valid and both strobes stay 0 and cmd_cs_n stays all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration word address (slots at 0..15, start at 16) |
| cfg_wdata | input | 32 | Configuration write data |
| status | output | 8 | Bit 0 busy, bits 4 and 6 run finished |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_code | output | 3 | Command code |
| cmd_addr | output | 16 | Column or mode-register address |
| cmd_bank | output | 3 | Bank number |
| cmd_cs_n | output | 4 | Active-low chip select, one bit per rank |
| rd_strobe | output | 1 | Issue belongs to a read-tagged slot |
| wr_strobe | output | 1 | Issue belongs to a write-tagged slot |

## Verification
Two things can land in the same clock edge. The first is the end of one slot together with the base-address reload of the next slot or the next pass, because address stepping and slot advance both act on the edge after the last issue. A zero post wait and loop repetition provoke this, and the next command's address is checked against the new base and not against the stepped value. The second is a start word arriving in the middle of a run, which the bench writes while the engine is busy; it is judged by the unchanged count of issued commands and the unchanged completion cycle.

// File: rtl/ds_pkg.sv
// Package: shared types and fixed start-word layout for the command sequencer.
// Assumes a 32-bit configuration write word.
package ds_pkg;
    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_ACT     = 3'd1,
        CMD_RD      = 3'd2,
        CMD_WR      = 3'd3,
        CMD_PRE     = 3'd4,
        CMD_MRS     = 3'd5,
        CMD_ZQCS    = 3'd6,
        CMD_NOP_ALT = 3'd7
    } ds_cmd_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_RD   = 2'd1,
        DIR_WR   = 2'd2
    } ds_dir_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2,
        ST_POST  = 2'd3
    } ds_state_e;

    localparam int CFG_DW        = 32;
    localparam int START_CNT_LSB = 18;
    localparam int START_TMR_BIT = 22;
endpackage

// File: rtl/ds_slot_regs.sv
// Slot register file: stores the per-slot command, timing, base address and
// stepping rules. Word address = slot*4 + register. Offers a read port for
// the slot being executed and one for the slot whose base is being loaded.
// Assumes writes outside the slot range are handled elsewhere.
module ds_slot_regs #(
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = 16,
    parameter int BANK_W  = 3,
    parameter int RANK_N  = 4,
    parameter int REP_W   = 10,
    parameter int GAP_W   = 8,
    parameter int POST_W  = 9,
    parameter int WRAP_W  = 5,
    parameter int CFG_AW  = 5,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int RANK_W = (RANK_N > 1) ? $clog2(RANK_N) : 1,
    localparam int VEC_W  = ADDR_W + BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CFG_AW-1:0]    waddr,
    input  logic [31:0]          wdata,
    input  logic [SLOT_W-1:0]    rd_idx,
    input  logic [SLOT_W-1:0]    ld_idx,
    output ds_pkg::ds_cmd_e      cur_cmd,
    output logic [REP_W-1:0]     cur_reps,
    output logic [GAP_W-1:0]     cur_gap,
    output logic [POST_W-1:0]    cur_post,
    output ds_pkg::ds_dir_e      cur_dir,
    output logic [RANK_W-1:0]    cur_rank,
    output logic                 cur_bank_step,
    output logic                 cur_col_step,
    output logic [WRAP_W-1:0]    cur_wrap,
    output logic [VEC_W-1:0]     ld_base
);
    localparam int GAP_LSB  = REP_W;
    localparam int POST_LSB = GAP_LSB + GAP_W;
    localparam int DIR_LSB  = POST_LSB + POST_W;
    localparam int CTRL_W   = DIR_LSB + 2;
    localparam int AREG_W   = VEC_W + RANK_W;
    localparam int UPD_W    = 2 + WRAP_W;

    logic [2:0]        cmd_q  [N_SLOTS];
    logic [CTRL_W-1:0] ctrl_q [N_SLOTS];
    logic [AREG_W-1:0] addr_q [N_SLOTS];
    logic [UPD_W-1:0]  upd_q  [N_SLOTS];

    logic                    in_range;
    logic [CFG_AW-3:0]       wslot;
    logic [1:0]              wreg;

    assign wslot    = waddr[CFG_AW-1:2];
    assign wreg     = waddr[1:0];
    assign in_range = we && (int'(waddr) < N_SLOTS * 4);

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        // Capture writes addressed to this slot's four registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmd_q[s]  <= '0;
                ctrl_q[s] <= '0;
                addr_q[s] <= '0;
                upd_q[s]  <= '0;
            end else if (in_range && int'(wslot) == s) begin
                case (wreg)
                    2'd0:    cmd_q[s]  <= wdata[2:0];
                    2'd1:    ctrl_q[s] <= wdata[CTRL_W-1:0];
                    2'd2:    addr_q[s] <= wdata[AREG_W-1:0];
                    default: upd_q[s]  <= wdata[UPD_W-1:0];
                endcase
            end
        end
    end

    // Decode the fields of the slot under execution.
    always_comb begin
        cur_cmd       = ds_pkg::ds_cmd_e'(cmd_q[rd_idx]);
        cur_reps      = ctrl_q[rd_idx][REP_W-1:0];
        cur_gap       = ctrl_q[rd_idx][GAP_LSB +: GAP_W];
        cur_post      = ctrl_q[rd_idx][POST_LSB +: POST_W];
        cur_dir       = ds_pkg::ds_dir_e'(ctrl_q[rd_idx][DIR_LSB +: 2]);
        cur_rank      = addr_q[rd_idx][VEC_W +: RANK_W];
        cur_bank_step = upd_q[rd_idx][0];
        cur_col_step  = upd_q[rd_idx][1];
        cur_wrap      = upd_q[rd_idx][2 +: WRAP_W];
        ld_base       = addr_q[ld_idx][VEC_W-1:0];
    end
endmodule

// File: rtl/ds_addr_step.sv
// Address stepper: holds the {bank, column} vector of the running slot,
// reloads it from a slot base and advances it after each issue. Only the
// low "wrap" bits take part in the step; wrap 0 freezes the vector.
// Assumes load has priority over step in the same cycle.
module ds_addr_step #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int WRAP_W = 5,
    parameter int COL_INC = 8,
    localparam int VEC_W = ADDR_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [VEC_W-1:0]  base,
    input  logic              step,
    input  logic              bank_step,
    input  logic              col_step,
    input  logic [WRAP_W-1:0] wrap,
    output logic [VEC_W-1:0]  vec
);
    logic [VEC_W-1:0] vec_q;
    logic [VEC_W-1:0] inc;
    logic [VEC_W-1:0] sum;
    logic [VEC_W-1:0] mask;
    logic [VEC_W-1:0] stepped;

    // Form the increment, the counting mask and the stepped vector.
    always_comb begin
        inc = '0;
        if (col_step)  inc = inc + VEC_W'(COL_INC);
        if (bank_step) inc = inc + (VEC_W'(1) << ADDR_W);
        sum = vec_q + inc;
        if (int'(wrap) >= VEC_W) mask = '1;
        else                     mask = (VEC_W'(1) << wrap) - VEC_W'(1);
        stepped = (vec_q & ~mask) | (sum & mask);
    end

    // Hold the working vector: reload on slot entry, advance after an issue.
    always_ff @(posedge clk) begin
        if (!rst_n)     vec_q <= '0;
        else if (load)  vec_q <= base;
        else if (step)  vec_q <= stepped;
    end

    assign vec = vec_q;

    // R6: a zero wrap leaves the vector unchanged across a step.
    a_r6_wrap_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && wrap == '0) |=> $stable(vec_q));
endmodule

// File: rtl/ds_seq_ctrl.sv
// Sequencing control: accepts a start word when idle, walks the slots in
// order, counts repeats, gap and post-wait cycles, repeats the list for the
// loop count and raises done at the end. Assumes slot fields are stable
// during a run.
module ds_seq_ctrl #(
    parameter int N_SLOTS = 4,
    parameter int REP_W   = 10,
    parameter int GAP_W   = 8,
    parameter int POST_W  = 9,
    parameter int LOOP_W  = 8,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int CNT_W  = (GAP_W > POST_W) ? GAP_W : POST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic [LOOP_W-1:0] start_loops,
    input  logic [SLOT_W-1:0] start_last,
    input  logic              start_timer,
    input  logic [REP_W-1:0]  reps,
    input  logic [GAP_W-1:0]  gap,
    input  logic [POST_W-1:0] post,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              issue,
    output logic              timer,
    output logic              load,
    output logic [SLOT_W-1:0] ld_idx,
    output logic              busy,
    output logic              done
);
    import ds_pkg::*;

    ds_state_e         state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d, last_q, last_d;
    logic [REP_W-1:0]  rep_q, rep_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [LOOP_W-1:0] loops_q, loops_d;
    logic              timer_q, timer_d, done_q, done_d;

    logic              at_last, end_run, more_reps, accept;
    logic [REP_W:0]    reps_eff;
    logic [SLOT_W-1:0] adv_slot;
    logic [LOOP_W-1:0] adv_loops;

    // Work out what leaving the current slot leads to.
    always_comb begin
        accept    = start_we && (state_q == ST_IDLE);
        at_last   = (slot_q == last_q);
        end_run   = at_last && (loops_q <= LOOP_W'(1));
        adv_slot  = at_last ? '0 : slot_q + SLOT_W'(1);
        adv_loops = at_last ? loops_q - LOOP_W'(1) : loops_q;
        reps_eff  = (reps == '0) ? (REP_W+1)'(1) : {1'b0, reps};
        more_reps = ({1'b0, rep_q} + (REP_W+1)'(1)) < reps_eff;
    end

    // Next-state logic for the slot walk and its counters.
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        last_d  = last_q;
        rep_d   = rep_q;
        cnt_d   = cnt_q;
        loops_d = loops_q;
        timer_d = timer_q;
        done_d  = done_q;
        load    = 1'b0;
        ld_idx  = slot_q;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_ISSUE;
                    slot_d  = '0;
                    last_d  = start_last;
                    rep_d   = '0;
                    loops_d = (start_loops == '0) ? LOOP_W'(1) : start_loops;
                    timer_d = start_timer;
                    done_d  = 1'b0;
                    load    = 1'b1;
                    ld_idx  = '0;
                end
            end
            ST_ISSUE: begin
                if (more_reps) begin
                    rep_d = rep_q + REP_W'(1);
                    if (gap > GAP_W'(1)) begin
                        state_d = ST_GAP;
                        cnt_d   = CNT_W'(gap) - CNT_W'(1);
                    end
                end else begin
                    rep_d = '0;
                    if (post != '0) begin
                        state_d = ST_POST;
                        cnt_d   = CNT_W'(post);
                    end else if (end_run) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        slot_d  = adv_slot;
                        loops_d = adv_loops;
                        load    = 1'b1;
                        ld_idx  = adv_slot;
                    end
                end
            end
            ST_GAP: begin
                if (cnt_q == CNT_W'(1)) state_d = ST_ISSUE;
                else                    cnt_d   = cnt_q - CNT_W'(1);
            end
            default: begin
                if (cnt_q != CNT_W'(1)) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else if (end_run) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else begin
                    state_d = ST_ISSUE;
                    slot_d  = adv_slot;
                    loops_d = adv_loops;
                    load    = 1'b1;
                    ld_idx  = adv_slot;
                end
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            last_q  <= '0;
            rep_q   <= '0;
            cnt_q   <= '0;
            loops_q <= '0;
            timer_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            last_q  <= last_d;
            rep_q   <= rep_d;
            cnt_q   <= cnt_d;
            loops_q <= loops_d;
            timer_q <= timer_d;
            done_q  <= done_d;
        end
    end

    assign slot_idx = slot_q;
    assign issue    = (state_q == ST_ISSUE);
    assign timer    = timer_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;

    // R11: a start word during a run leaves the run's slot range and mode alone.
    a_r11_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_we) |=> ($stable(last_q) && $stable(timer_q)));

    // R10: an accepted start clears completion and makes the engine busy.
    a_r10_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!done && busy));

    // R10: completion only ever follows a busy cycle.
    a_r10_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R4: a gap count above one keeps the engine quiet in the following cycle.
    a_r4_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && cnt_q != CNT_W'(1)) |=> !issue);
endmodule

// File: rtl/ds_cmd_sequencer.sv
// Top of the DRAM command subsequence sequencer. Decodes the configuration
// port into slot writes and start words, ties the slot store, the sequencing
// control and the address stepper together, and forms the command bus,
// chip selects, strobes and status. Assumes one channel and a single clock.
module ds_cmd_sequencer #(
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = 16,
    parameter int BANK_W  = 3,
    parameter int RANK_N  = 4,
    parameter int REP_W   = 10,
    parameter int GAP_W   = 8,
    parameter int POST_W  = 9,
    parameter int LOOP_W  = 8,
    parameter int WRAP_W  = 5,
    localparam int CFG_AW = $clog2(N_SLOTS * 4 + 1),
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int RANK_W = (RANK_N > 1) ? $clog2(RANK_N) : 1,
    localparam int VEC_W  = ADDR_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [7:0]        status,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [RANK_N-1:0] cmd_cs_n,
    output logic              rd_strobe,
    output logic              wr_strobe
);
    import ds_pkg::*;

    localparam int START_ADDR = N_SLOTS * 4;

    logic              start_we;
    logic [SLOT_W-1:0] slot_idx, ld_idx;
    logic              issue, timer, load, busy, done;
    ds_cmd_e           cur_cmd;
    logic [REP_W-1:0]  cur_reps;
    logic [GAP_W-1:0]  cur_gap;
    logic [POST_W-1:0] cur_post;
    ds_dir_e           cur_dir;
    logic [RANK_W-1:0] cur_rank;
    logic              cur_bank_step, cur_col_step;
    logic [WRAP_W-1:0] cur_wrap;
    logic [VEC_W-1:0]  ld_base, vec;
    logic              live;

    assign start_we = cfg_we && (int'(cfg_addr) == START_ADDR);

    ds_slot_regs #(
        .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .RANK_N(RANK_N),
        .REP_W(REP_W), .GAP_W(GAP_W), .POST_W(POST_W), .WRAP_W(WRAP_W),
        .CFG_AW(CFG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
        .wdata(cfg_wdata), .rd_idx(slot_idx), .ld_idx(ld_idx),
        .cur_cmd(cur_cmd), .cur_reps(cur_reps), .cur_gap(cur_gap),
        .cur_post(cur_post), .cur_dir(cur_dir), .cur_rank(cur_rank),
        .cur_bank_step(cur_bank_step), .cur_col_step(cur_col_step),
        .cur_wrap(cur_wrap), .ld_base(ld_base)
    );

    ds_seq_ctrl #(
        .N_SLOTS(N_SLOTS), .REP_W(REP_W), .GAP_W(GAP_W), .POST_W(POST_W),
        .LOOP_W(LOOP_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_we(start_we),
        .start_loops(cfg_wdata[LOOP_W-1:0]),
        .start_last(cfg_wdata[START_CNT_LSB +: SLOT_W]),
        .start_timer(cfg_wdata[START_TMR_BIT]),
        .reps(cur_reps), .gap(cur_gap), .post(cur_post),
        .slot_idx(slot_idx), .issue(issue), .timer(timer), .load(load),
        .ld_idx(ld_idx), .busy(busy), .done(done)
    );

    ds_addr_step #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .WRAP_W(WRAP_W)
    ) u_step (
        .clk(clk), .rst_n(rst_n), .load(load), .base(ld_base),
        .step(issue), .bank_step(cur_bank_step), .col_step(cur_col_step),
        .wrap(cur_wrap), .vec(vec)
    );

    // Drive the command bus, chip selects and strobes for a live issue.
    always_comb begin
        live      = issue && !timer;
        cmd_valid = live;
        cmd_code  = live ? cur_cmd : CMD_NOP;
        cmd_addr  = vec[ADDR_W-1:0];
        cmd_bank  = vec[VEC_W-1:ADDR_W];
        cmd_cs_n  = live ? ~(RANK_N'(1) << cur_rank) : '1;
        rd_strobe = live && (cur_dir == DIR_RD);
        wr_strobe = live && (cur_dir == DIR_WR);
        status    = {1'b0, done, 1'b0, done, 3'b000, busy};
    end

    // R7: one rank selected during an issue.
    a_r7_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($countones(~cmd_cs_n) == 1));

    // R7: no rank selected between issues.
    a_r7_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (&cmd_cs_n));

    // R8: strobes are exclusive and only accompany an issue.
    a_r8_strobe_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe) |-> (cmd_valid && !(rd_strobe && wr_strobe)));

    // R12: timer mode never drives a command.
    a_r12_timer_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && timer) |-> !cmd_valid);
endmodule

// File: tb/ds_cmd_sequencer_tb.sv
module ds_cmd_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXEV = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  status;
    logic        cmd_valid;
    logic [2:0]  cmd_code;
    logic [15:0] cmd_addr;
    logic [2:0]  cmd_bank;
    logic [3:0]  cmd_cs_n;
    logic        rd_strobe, wr_strobe;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int ev_n = 0;
    int done_cyc = -1;
    int ev_cyc  [MAXEV];
    int ev_code [MAXEV];
    int ev_addr [MAXEV];
    int ev_bank [MAXEV];
    int ev_cs   [MAXEV];
    int ev_rd   [MAXEV];
    int ev_wr   [MAXEV];
    logic done_prev = 1'b0;

    ds_cmd_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .status(status), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank),
        .cmd_cs_n(cmd_cs_n), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Logger: samples outputs at each falling edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cmd_valid && ev_n < MAXEV) begin
            ev_cyc[ev_n]  <= cyc + 1;
            ev_code[ev_n] <= int'(cmd_code);
            ev_addr[ev_n] <= int'(cmd_addr);
            ev_bank[ev_n] <= int'(cmd_bank);
            ev_cs[ev_n]   <= int'(cmd_cs_n);
            ev_rd[ev_n]   <= int'(rd_strobe);
            ev_wr[ev_n]   <= int'(wr_strobe);
            ev_n <= ev_n + 1;
        end
        if ((rd_strobe || wr_strobe) && !cmd_valid) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL R8 strobe without command: actual 1 expected 0");
        end
        if (status[4] && !done_prev && done_cyc < 0) done_cyc <= cyc + 1;
        done_prev <= status[4];
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 100000);
        fails = fails + 1;
        tests = tests + 1;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 32'(d);
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    function automatic int mk_ctrl(int reps, int gap, int post, int dir);
        return reps | (gap << 10) | (post << 18) | (dir << 27);
    endfunction
    function automatic int mk_addr(int a, int bank, int rank);
        return a | (bank << 16) | (rank << 19);
    endfunction
    function automatic int mk_upd(int bk, int col, int wrap);
        return bk | (col << 1) | (wrap << 2);
    endfunction

    task automatic slot(input int i, input int cmd, input int ctrl, input int ad, input int upd);
        wr(i*4+0, cmd);
        wr(i*4+1, ctrl);
        wr(i*4+2, ad);
        wr(i*4+3, upd);
    endtask

    // Start a run; s is the cycle of the write, first issue lands at s+1.
    task automatic start(input int loops, input int nslots, input int tmr, output int s);
        @(negedge clk); #1;
        ev_n = 0; done_cyc = -1;
        cfg_we = 1'b1; cfg_addr = 5'd16;
        cfg_wdata = 32'(loops | ((nslots-1) << 18) | (tmr << 22));
        s = cyc;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk); #1;
            if (!status[0]) break;
        end
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 status", int'(status), 0);
        chk("R1 cmd_valid", int'(cmd_valid), 0);
        chk("R1 cs_n", int'(cmd_cs_n), 15);
        chk("R1 strobes", int'(rd_strobe) + int'(wr_strobe), 0);
    endtask

    task automatic t_single();
        int s;
        slot(0, 4, mk_ctrl(1, 0, 5, 0), mk_addr(16'h400, 0, 2), 0);
        start(1, 1, 0, s);
        chk("R10 busy after start", int'(status), 1);
        wait_end();
        chk("R2 event count", ev_n, 1);
        chk("R2 first issue cycle", ev_cyc[0] - s, 1);
        chk("R3 PRE code", ev_code[0], 4);
        chk("R3 precharge-all address", ev_addr[0], 16'h400);
        chk("R7 cs_n rank 2", ev_cs[0], 4'b1011);
        chk("R8 no strobe", ev_rd[0] + ev_wr[0], 0);
        chk("R10 done cycle", done_cyc - s, 1 + 5 + 1);
        chk("R10 status done", int'(status), 8'h50);
    endtask

    task automatic t_repeat_gap();
        int s;
        slot(0, 2, mk_ctrl(5, 4, 0, 1), mk_addr(0, 1, 0), mk_upd(0, 1, 18));
        start(1, 1, 0, s);
        wait_end();
        chk("R4 repeat count", ev_n, 5);
        for (int i = 0; i < 5; i++) begin
            chk("R4 gap spacing", ev_cyc[i] - s, 1 + 4*i);
            chk("R6 column step", ev_addr[i], 8*i);
            chk("R8 read strobe", ev_rd[i], 1);
            chk("R7 cs_n rank 0", ev_cs[i], 4'b1110);
        end
        chk("R4 done after last", done_cyc - s, 1 + 16 + 1);
    endtask

    task automatic t_stepping();
        int s;
        int exp_col [5] = '{'h1A8, 'h1B0, 'h1B8, 'h1A0, 'h1A8};
        // Bank step with wrap 18: bank bit 2 held, low two bank bits count.
        slot(0, 1, mk_ctrl(8, 2, 0, 0), mk_addr(16'h10, 4, 3), mk_upd(1, 0, 18));
        start(1, 1, 0, s);
        wait_end();
        chk("R6 bank events", ev_n, 8);
        for (int i = 0; i < 8; i++) begin
            chk("R6 bank wrap", ev_bank[i], 4 + (i % 4));
            chk("R6 column held", ev_addr[i], 16'h10);
            chk("R4 gap 2", ev_cyc[i] - s, 1 + 2*i);
        end
        // Column wrap of 5 bits.
        slot(0, 2, mk_ctrl(5, 1, 0, 1), mk_addr(16'h1A8, 0, 1), mk_upd(0, 1, 5));
        start(1, 1, 0, s);
        wait_end();
        chk("R6 col wrap events", ev_n, 5);
        for (int i = 0; i < 5; i++) begin
            chk("R6 column wrap", ev_addr[i], exp_col[i]);
            chk("R4 gap 1 back to back", ev_cyc[i] - s, 1 + i);
        end
        // Wrap 0 disables stepping; gap 0 behaves as 1.
        slot(0, 3, mk_ctrl(3, 0, 0, 2), mk_addr(16'h55, 2, 1), mk_upd(1, 1, 0));
        start(1, 1, 0, s);
        wait_end();
        chk("R6 wrap0 events", ev_n, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R6 wrap0 address held", ev_addr[i], 16'h55);
            chk("R6 wrap0 bank held", ev_bank[i], 2);
            chk("R4 gap 0 as 1", ev_cyc[i] - s, 1 + i);
            chk("R8 write strobe", ev_wr[i], 1);
        end
    endtask

    task automatic t_multi_slot();
        int s;
        int exp_t  [6] = '{0, 4, 8, 11, 14, 15};
        int exp_c  [6] = '{5, 3, 3, 2, 2, 4};
        int exp_a  [6] = '{4, 0, 8, 0, 8, 'h400};
        int exp_wr [6] = '{0, 1, 1, 0, 0, 0};
        int exp_rd [6] = '{0, 0, 0, 1, 1, 0};
        slot(0, 5, mk_ctrl(1, 0, 3, 0), mk_addr(4, 3, 1), 0);
        slot(1, 3, mk_ctrl(2, 4, 2, 2), mk_addr(0, 0, 1), mk_upd(0, 1, 18));
        slot(2, 2, mk_ctrl(2, 3, 0, 1), mk_addr(0, 0, 1), mk_upd(0, 1, 18));
        slot(3, 4, mk_ctrl(1, 0, 1, 0), mk_addr(16'h400, 0, 1), 0);
        start(1, 4, 0, s);
        wait_end();
        chk("R5 four-slot events", ev_n, 6);
        for (int i = 0; i < 6; i++) begin
            chk("R5 slot timing", ev_cyc[i] - s - 1, exp_t[i]);
            chk("R5 slot order code", ev_code[i], exp_c[i]);
            chk("R6 base reload per slot", ev_addr[i], exp_a[i]);
            chk("R8 wr strobe", ev_wr[i], exp_wr[i]);
            chk("R8 rd strobe", ev_rd[i], exp_rd[i]);
        end
        chk("R5 done cycle", done_cyc - s, 18);
        start(1, 2, 0, s);
        wait_end();
        chk("R2 two valid slots", ev_n, 3);
        chk("R2 two slot done", done_cyc - s, 1 + 8 + 2 + 1);
    endtask

    task automatic t_loops();
        int s;
        slot(0, 2, mk_ctrl(2, 2, 1, 1), mk_addr(0, 0, 0), mk_upd(0, 1, 18));
        start(3, 1, 0, s);
        wait_end();
        chk("R9 loop events", ev_n, 6);
        for (int i = 0; i < 6; i++) begin
            chk("R9 loop timing", ev_cyc[i] - s - 1, 2*i);
            chk("R9 base reload per pass", ev_addr[i], 8*(i % 2));
        end
        chk("R9 loop done", done_cyc - s, 13);
        start(0, 1, 0, s);
        wait_end();
        chk("R2 loop 0 runs once", ev_n, 2);
    endtask

    task automatic t_busy_ignore();
        int s;
        slot(0, 0, mk_ctrl(1, 0, 30, 0), mk_addr(0, 0, 3), 0);
        start(1, 1, 0, s);
        repeat (5) @(negedge clk);
        #1;
        cfg_we = 1'b1; cfg_addr = 5'd16; cfg_wdata = 32'(4 | (1 << 22));
        @(negedge clk); #1;
        cfg_we = 1'b0;
        wait_end();
        chk("R11 events unchanged", ev_n, 1);
        chk("R11 done unchanged", done_cyc - s, 32);
        // Start after done clears completion in the next cycle.
        start(1, 1, 0, s);
        chk("R10 status cleared on restart", int'(status), 1);
        wait_end();
        chk("R10 done again", int'(status), 8'h50);
    endtask

    task automatic t_timer();
        int s;
        int quiet;
        slot(0, 3, mk_ctrl(3, 2, 4, 2), mk_addr(0, 0, 2), 0);
        start(1, 1, 1, s);
        quiet = 1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); #1;
            if (cmd_valid || rd_strobe || wr_strobe || cmd_cs_n != 4'hF) quiet = 0;
        end
        wait_end();
        chk("R12 no commands", ev_n, 0);
        chk("R12 outputs quiet", quiet, 1);
        chk("R12 done timing", done_cyc - s, 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_single();
        t_repeat_gap();
        t_stepping();
        t_multi_slot();
        t_loops();
        t_busy_ignore();
        t_timer();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule